// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block watches the read cycles a host makes to a nonvolatile static memory. It turns two fixed six-step read patterns into one-cycle commands for the engine that moves data between the SRAM and the nonvolatile array. The first five steps are the same for both patterns. The sixth address selects the command: one value asks for a save into the nonvolatile array, and the other asks for a restore back into the SRAM.

Each step is an enabled read that the host qualifies with a read-cycle strobe. The block samples the strobe on a rising clock edge. A write, or a read that does not fit the pattern, breaks the match. If the stray read is at the first pattern address, it starts a new match. When a command is issued, a disable flag rises and holds off all further host accesses until the engine reports done. A save command issued this way does not depend on whether the SRAM has been written since the last nonvolatile transfer.

Top module: `nvseq_cmd_top`

## Requirements
- R1: During reset and after it, save_o, restore_o and lock_o are low and the matcher is idle.
- R2: Five strobed reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0 in that order, then a strobed read at 0x0F0F, raise save_o for exactly one cycle. The pulse comes in the cycle after the edge that samples the sixth strobe.
- R3: The same five reads followed by a strobed read at 0x0F0E raise restore_o for exactly one cycle, with the same timing as R2.
- R4: lock_o rises together with a command pulse. It stays high until the edge that samples done_i high, and is low from the next cycle. done_i has no effect while lock_o is low.
- R5: While lock_o is high, strobed accesses are ignored and the matcher stays idle. After release, a lone sixth-step read issues nothing.
- R6: A strobed read at any address other than the expected one aborts the pattern, and the sixth read then issues nothing.
- R7: An aborting read at 0x0000 counts as step one of a new pattern.
- R8: Any cycle with ce_ni and we_ni both low returns the matcher to idle, with or without a strobe. A write earlier does not prevent a later complete pattern from issuing a save.
- R9: A strobe with ce_ni high is not an access. It neither advances nor aborts the pattern.
- R10: lock_o stays low while steps one to five are accepted, so those reads are served normally.
- R11: A sixth read at an address that is neither terminal value aborts, and the matcher returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Host address |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rd_stb_i | input | 1 | One-cycle strobe marking the start of an access |
| done_i | input | 1 | Engine finished the current save or restore |
| save_o | output | 1 | One-cycle save command |
| restore_o | output | 1 | One-cycle restore command |
| lock_o | output | 1 | Host accesses disabled while high |

## Verification
The hardest state to reach is a pattern attempted while the block is locked. The bench must first complete a real save to raise lock_o. It then replays all five prefix reads and a terminal read before done_i arrives. After release, it sends a lone terminal read to show that none of the locked reads moved the matcher. Self-restart on 0x0000 is reached by breaking a pattern at step three with that exact address. Write-without-strobe is reached by dropping both enables between strobes.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int unsigned AW     = 13;
  localparam int unsigned PRE_N  = 5;
  localparam int unsigned STEP_W = $clog2(PRE_N + 1);

  typedef logic [AW-1:0]     addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam addr_t PRE_ADDR [PRE_N] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
  localparam addr_t SAVE_ADDR    = 13'h0F0F;
  localparam addr_t RESTORE_ADDR = 13'h0F0E;
endpackage

// File: rtl/nvseq_match.sv
module nvseq_match
  import nvseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_i,
  input  logic  wr_i,
  input  logic  hold_i,
  input  addr_t addr_i,
  output logic  fire_save_o,
  output logic  fire_restore_o
);
  step_t            step_q, step_d;
  logic [PRE_N-1:0] hit_vec;
  logic             pre_hit, last, rd_ok;

  for (genvar g = 0; g < PRE_N; g++) begin : g_hit
    assign hit_vec[g] = (addr_i == PRE_ADDR[g]);
  end

  always_comb begin
    pre_hit = 1'b0;
    for (int i = 0; i < PRE_N; i++)
      if (step_q == step_t'(i)) pre_hit = hit_vec[i];
  end

  assign last           = (step_q == step_t'(PRE_N));
  assign rd_ok          = rd_i & ~hold_i & ~wr_i;
  assign fire_save_o    = rd_ok & last & (addr_i == SAVE_ADDR);
  assign fire_restore_o = rd_ok & last & (addr_i == RESTORE_ADDR);

  always_comb begin
    step_d = step_q;
    if (hold_i || wr_i)                      step_d = '0;
    else if (rd_i) begin
      if (!last && pre_hit)                  step_d = step_q + step_t'(1);
      else if (fire_save_o || fire_restore_o) step_d = '0;
      else if (hit_vec[0])                   step_d = step_t'(1);  // restart on first address
      else                                   step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;

  assert_write_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (step_q == '0));
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (step_q == '0));
  assert_step_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= step_t'(PRE_N));
endmodule

// File: rtl/nvseq_issue.sv
module nvseq_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_save_i,
  input  logic fire_restore_i,
  input  logic done_i,
  output logic save_o,
  output logic restore_o,
  output logic lock_o
);
  logic save_q, restore_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      save_q    <= fire_save_i;
      restore_q <= fire_restore_i;
      if (fire_save_i || fire_restore_i) lock_q <= 1'b1;
      else if (done_i)                   lock_q <= 1'b0;
    end

  assign save_o    = save_q;
  assign restore_o = restore_q;
  assign lock_o    = lock_q;

  assert_save_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_q |=> !save_q);
  assert_restore_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_q |=> !restore_q);
  assert_cmd_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_q && restore_q));
  assert_cmd_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_q || restore_q) |-> lock_q);
  assert_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !done_i) |=> lock_q);
  assert_locked_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> !(save_q || restore_q));
endmodule

// File: rtl/nvseq_cmd_top.sv
module nvseq_cmd_top
  import nvseq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          rd_stb_i,
  input  logic          done_i,
  output logic          save_o,
  output logic          restore_o,
  output logic          lock_o
);
  logic rd, wr, fire_save, fire_restore;

  assign rd = rd_stb_i & ~ce_ni & we_ni;
  assign wr = ~ce_ni & ~we_ni;

  nvseq_match u_match (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_i           (rd),
    .wr_i           (wr),
    .hold_i         (lock_o),
    .addr_i         (addr_i),
    .fire_save_o    (fire_save),
    .fire_restore_o (fire_restore)
  );

  nvseq_issue u_issue (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fire_save_i    (fire_save),
    .fire_restore_i (fire_restore),
    .done_i         (done_i),
    .save_o         (save_o),
    .restore_o      (restore_o),
    .lock_o         (lock_o)
  );
endmodule

// File: tb/nvseq_cmd_top_tb.sv
module nvseq_cmd_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, stb = 1'b0, done = 1'b0;
  logic        save, restore, lock;

  typedef struct {bit s; bit r; bit l; int due; string tag;} exp_t;
  exp_t q[$];
  exp_t me;
  int   cyc = 0, n_cmp = 0, n_bad = 0;
  bit   fin = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvseq_cmd_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .we_ni(we_n),
    .rd_stb_i(stb), .done_i(done), .save_o(save), .restore_o(restore), .lock_o(lock)
  );

  always @(negedge clk)
    while (q.size() > 0 && q[0].due == cyc) begin
      me = q.pop_front();
      n_cmp++;
      if (save !== me.s || restore !== me.r || lock !== me.l) begin
        n_bad++;
        $display("FAIL %s: got save=%b restore=%b lock=%b, exp save=%b restore=%b lock=%b",
                 me.tag, save, restore, lock, me.s, me.r, me.l);
      end
    end

  task automatic expect_nx(bit s, bit r, bit l, string tag);
    exp_t e;
    e.s = s; e.r = r; e.l = l; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic acc(logic [12:0] a, bit ce, bit we, bit st, bit s, bit r, bit l, string tag);
    @(negedge clk);
    addr = a; ce_n = ce; we_n = we; stb = st; done = 1'b0;
    expect_nx(s, r, l, tag);
  endtask

  task automatic rd(logic [12:0] a, bit s, bit r, bit l, string tag);
    acc(a, 1'b0, 1'b1, 1'b1, s, r, l, tag);
  endtask

  task automatic idle(bit l, string tag);
    acc(13'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, l, tag);
  endtask

  task automatic fin_done(string tag);
    @(negedge clk);
    stb = 1'b0; ce_n = 1'b1; we_n = 1'b1; done = 1'b1;
    expect_nx(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic prefix(bit l, string tag);
    rd(13'h0000, 0, 0, l, tag);
    rd(13'h1555, 0, 0, l, tag);
    rd(13'h0AAA, 0, 0, l, tag);
    rd(13'h1FFF, 0, 0, l, tag);
    rd(13'h10F0, 0, 0, l, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, exp completion (R1)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    expect_nx(0, 0, 0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(0, "R1 after reset");
    // R10 + R2: save pattern
    prefix(0, "R10 prefix unlocked");
    rd(13'h0F0F, 1, 0, 1, "R2 save pulse");
    idle(1, "R2 single pulse / R4 lock held");
    // R5: pattern while locked is ignored
    prefix(1, "R5 locked prefix");
    rd(13'h0F0E, 0, 0, 1, "R5 locked terminal");
    fin_done("R4 release on done");
    rd(13'h0F0F, 0, 0, 0, "R5 matcher idle after lock");
    // R3: restore pattern
    prefix(0, "R3 prefix");
    rd(13'h0F0E, 0, 1, 1, "R3 restore pulse");
    idle(1, "R3 single pulse");
    fin_done("R4 release after restore");
    // R4: done while unlocked has no effect
    fin_done("R4 done ignored when unlocked");
    idle(0, "R4 still unlocked");
    // R6: stray read aborts
    rd(13'h0000, 0, 0, 0, "R6");
    rd(13'h1555, 0, 0, 0, "R6");
    rd(13'h0123, 0, 0, 0, "R6 stray");
    rd(13'h1FFF, 0, 0, 0, "R6");
    rd(13'h10F0, 0, 0, 0, "R6");
    rd(13'h0F0F, 0, 0, 0, "R6 no command");
    // R7: abort on 0x0000 restarts
    rd(13'h0000, 0, 0, 0, "R7");
    rd(13'h1555, 0, 0, 0, "R7");
    rd(13'h0000, 0, 0, 0, "R7 restart");
    rd(13'h1555, 0, 0, 0, "R7");
    rd(13'h0AAA, 0, 0, 0, "R7");
    rd(13'h1FFF, 0, 0, 0, "R7");
    rd(13'h10F0, 0, 0, 0, "R7");
    rd(13'h0F0F, 1, 0, 1, "R7 save after restart");
    fin_done("R7 release");
    // R8: write without strobe resets
    prefix(0, "R8 prefix");
    acc(13'h0777, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R8 write no strobe");
    rd(13'h0F0F, 0, 0, 0, "R8 aborted by write");
    prefix(0, "R8 prefix after write");
    acc(13'h0F0F, 1'b0, 1'b0, 1'b1, 0, 0, 0, "R8 strobed write at terminal");
    prefix(0, "R8 again");
    rd(13'h0F0F, 1, 0, 1, "R8 save despite earlier writes");
    fin_done("R8 release");
    // R9: strobe with ce high is not an access
    prefix(0, "R9 prefix");
    acc(13'h0555, 1'b1, 1'b1, 1'b1, 0, 0, 0, "R9 deselected strobe");
    acc(13'h0555, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R9 deselected write");
    rd(13'h0F0F, 1, 0, 1, "R9 save still issued");
    fin_done("R9 release");
    // R11: bad terminal
    prefix(0, "R11 prefix");
    rd(13'h0F0D, 0, 0, 0, "R11 bad terminal");
    rd(13'h0F0F, 0, 0, 0, "R11 idle after abort");
    idle(0, "R11 end");
    repeat (3) @(negedge clk);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule